// File: doc/BRIEF.md
# Codec Port Frame-Sync Timing Generator

This block is the master-side timing source for a synchronous serial codec port. A fast input clock is divided into a shift clock (SCLK). SCLK in turn is counted into sample periods. Each period opens with an active-low frame-sync pulse that brackets one 16-bit primary data transfer. When a secondary (control) transfer has been requested, a second frame-sync pulse is placed halfway through the same period. A request comes either from a dedicated request input, or from the least significant bit of the incoming primary word when that option is enabled.

Besides SCLK and frame-sync, the block drives a delayed frame-sync for one downstream slave device. That pulse has the same length as the master's own pulse and starts where the master's pulse ends. It also drives an interval flag that marks whether the port is in the primary or the secondary part of the period. The SCLK half-period and the period length, which is 256 or 512 SCLK cycles, are taken from the divider and cascade-size inputs once per period, at its opening edge. Serial data shifting and register storage belong to neighbouring blocks.

Top module: `fsg_timing_gen`

## Requirements
- R1: While `rst_n` is low, `fs_n` and `fsd_n` are 1 and `sclk` and `sec_flag` are 0. After release the active half-period is 32 clocks whatever `div_n` holds. The first SCLK rise therefore comes on the 32nd clock edge after release, and `fs_n` falls on that same edge.
- R2: SCLK stays high for N clock cycles and low for N clock cycles, where N is `div_n` and the code 0 stands for 32. One period therefore lasts 2·N·(SCLK cycles per period) clocks.
- R3: With `big_cascade` = 0 a period spans 256 SCLK cycles. `fs_n` falls on the SCLK rise that opens the period and stays low for exactly 16 SCLK cycles. `fs_n` only ever changes together with an SCLK rising edge.
- R4: With `big_cascade` = 1 a period spans 512 SCLK cycles.
- R5: If `fc_req` is 1 at the SCLK rise that closes the 16th primary bit (the rise on which `fs_n` returns high), exactly one secondary frame follows. Its `fs_n` falls 128 SCLK cycles after the primary fall, or 256 with `big_cascade` = 1, and stays low for 16 SCLK cycles.
- R6: Without a request at that edge no secondary frame occurs in the period. `fc_req` is ignored at every other time.
- R7: With `lsb_req_en` = 1, `din` is sampled on the SCLK falling edge inside the 16th primary bit slot, which carries the word's LSB. A sampled 1 requests a secondary frame. With `lsb_req_en` = 0, `din` has no effect.
- R8: `sec_flag` rises together with the secondary `fs_n` fall and drops together with the next primary `fs_n` fall. It stays 0 for a whole period that has no secondary frame.
- R9: `fsd_n` goes low for 16 SCLK cycles starting at the SCLK rise where `fs_n` returns high, after both primary and secondary frames. It is never low while `fs_n` is low.
- R10: `div_n` and `big_cascade` are taken only at the SCLK rise that opens a period. Changing them mid-period leaves the running period unchanged, and the new values apply from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock; SCLK half-period counts its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| div_n | input | 5 | SCLK half-period N in clocks, 0 encodes 32 |
| big_cascade | input | 1 | 1 selects 512 SCLK cycles per period, 0 selects 256 |
| fc_req | input | 1 | Hardware request for a secondary transfer |
| lsb_req_en | input | 1 | Enables requests through the primary word's LSB |
| din | input | 1 | Serial data arriving from the host, LSB sampled for requests |
| sclk | output | 1 | Shift clock |
| fs_n | output | 1 | Active-low frame-sync |
| fsd_n | output | 1 | Active-low delayed frame-sync for a slave |
| sec_flag | output | 1 | 0 in the primary interval, 1 in the secondary interval |

## Verification
The hardest situation to reach from the ports is a request that arrives outside its single sampling edge, because the generator has to ignore it. The bench waits until it observes `fs_n` returning high, which means the sampling edge has just passed. It then raises `fc_req` and holds it across much of the period, and drops it well before the next period's sampling edge. A second hard case is a divider change in the middle of a period. The bench makes that change after the same observed edge and checks that the running period keeps its old length while the following period takes the new one.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  // Bits in one serial transfer, primary or secondary.
  localparam int WORD_BITS = 16;

  // Registered pin bundle leaving the frame shaper.
  typedef struct packed {
    logic fs_n;
    logic fsd_n;
    logic flag;
  } fsg_pins_t;
endpackage

// File: rtl/fsg_sclk_div.sv
// Divides the fast clock into SCLK; each half-period lasts half_len cycles.
module fsg_sclk_div #(
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] half_len,
  output logic          sclk,
  output logic          rise_tick,
  output logic          fall_tick
);
  logic [HW-1:0] h_q, h_d;
  logic          sclk_q, sclk_d;
  logic          at_end;

  always_comb begin
    at_end = (h_q == half_len - HW'(1));
    h_d    = at_end ? '0 : h_q + HW'(1);
    sclk_d = at_end ? ~sclk_q : sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_q    <= '0;
      sclk_q <= 1'b0;
    end else begin
      h_q    <= h_d;
      sclk_q <= sclk_d;
    end
  end

  // Tick strobes mark the clock edge on which SCLK is about to change.
  assign rise_tick = at_end & ~sclk_q;
  assign fall_tick = at_end &  sclk_q;
  assign sclk      = sclk_q;
endmodule

// File: rtl/fsg_slot_ctr.sv
// Counts SCLK cycles within a sample period and latches the period settings
// at the SCLK rise that opens each period.
module fsg_slot_ctr #(
  parameter int N_MAX      = 32,
  parameter int BASE_SLOTS = 256,
  parameter int NW         = 5,
  parameter int HW         = 6,
  parameter int SW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_tick,
  input  logic [NW-1:0] div_n,
  input  logic          big_in,
  output logic [SW-1:0] slot_q,
  output logic [SW-1:0] slot_d,
  output logic          big_d,
  output logic [HW-1:0] half_len,
  output logic          wrap
);
  localparam logic [SW-1:0] LAST_SMALL = SW'(BASE_SLOTS - 1);
  localparam logic [SW-1:0] LAST_BIG   = SW'(2 * BASE_SLOTS - 1);
  localparam logic [HW-1:0] HALF_RST   = HW'(N_MAX);

  logic          big_q;
  logic [HW-1:0] half_q, half_d, half_dec;
  logic [SW-1:0] last_slot;

  always_comb begin
    last_slot = big_q ? LAST_BIG : LAST_SMALL;
    wrap      = rise_tick && (slot_q == last_slot);
    half_dec  = (div_n == '0) ? HALF_RST : HW'(div_n);
    if (wrap)           slot_d = '0;
    else if (rise_tick) slot_d = slot_q + SW'(1);
    else                slot_d = slot_q;
    big_d  = wrap ? big_in   : big_q;
    half_d = wrap ? half_dec : half_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= LAST_SMALL;
      big_q  <= 1'b0;
      half_q <= HALF_RST;
    end else if (rise_tick) begin
      slot_q <= slot_d;
      big_q  <= big_d;
      half_q <= half_d;
    end
  end

  assign half_len = half_q;
endmodule

// File: rtl/fsg_req_ctl.sv
// Decides once per period, at the end of the primary word, whether a
// secondary transfer follows; the decision is dropped when the period wraps.
module fsg_req_ctl #(
  parameter int SW        = 9,
  parameter int WORD_BITS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_tick,
  input  logic          fall_tick,
  input  logic          wrap,
  input  logic [SW-1:0] slot_q,
  input  logic          fc_req,
  input  logic          lsb_req_en,
  input  logic          din,
  output logic          sec_d
);
  localparam logic [SW-1:0] END_SLOT = SW'(WORD_BITS - 1);

  logic lsb_q, lsb_d, lsb_en;
  logic sec_q;
  logic end_word;

  always_comb begin
    end_word = (slot_q == END_SLOT);
    lsb_en   = fall_tick && end_word;
    lsb_d    = din;
    if (wrap)                       sec_d = 1'b0;
    else if (rise_tick && end_word) sec_d = fc_req | (lsb_req_en & lsb_q);
    else                            sec_d = sec_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lsb_q <= 1'b0;
    end else if (lsb_en) begin
      lsb_q <= lsb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= 1'b0;
    end else if (rise_tick) begin
      sec_q <= sec_d;
    end
  end
endmodule

// File: rtl/fsg_frame_out.sv
// Shapes frame-sync, delayed frame-sync and the interval flag from the slot
// that the next SCLK rise enters; all pins change on that rise only.
module fsg_frame_out
  import fsg_pkg::*;
#(
  parameter int SW         = 9,
  parameter int BASE_SLOTS = 256,
  parameter int WORD_BITS  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_tick,
  input  logic [SW-1:0] slot_d,
  input  logic          big_d,
  input  logic          sec_d,
  output fsg_pins_t     pins
);
  localparam int NWIN = 2;  // window 0: primary, window 1: secondary

  logic [SW-1:0]   mid_slot;
  logic [NWIN-1:0] in_fs, in_fsd, win_on;
  fsg_pins_t       pins_q, pins_d;

  always_comb begin
    mid_slot = big_d ? SW'(BASE_SLOTS) : SW'(BASE_SLOTS / 2);
    win_on   = {sec_d, 1'b1};
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic [SW-1:0] lo;
    assign lo = (w == 0) ? '0 : mid_slot;
    assign in_fs[w]  = win_on[w] && (slot_d >= lo) &&
                       (slot_d < lo + SW'(WORD_BITS));
    assign in_fsd[w] = win_on[w] && (slot_d >= lo + SW'(WORD_BITS)) &&
                       (slot_d < lo + SW'(2 * WORD_BITS));
  end

  always_comb begin
    pins_d.fs_n  = ~(|in_fs);
    pins_d.fsd_n = ~(|in_fsd);
    pins_d.flag  = sec_d && (slot_d >= mid_slot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pins_q <= '{fs_n: 1'b1, fsd_n: 1'b1, flag: 1'b0};
    end else if (rise_tick) begin
      pins_q <= pins_d;
    end
  end

  assign pins = pins_q;
endmodule

// File: rtl/fsg_timing_gen.sv
module fsg_timing_gen
  import fsg_pkg::*;
#(
  parameter int N_MAX      = 32,
  parameter int BASE_SLOTS = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(N_MAX)-1:0] div_n,
  input  logic                     big_cascade,
  input  logic                     fc_req,
  input  logic                     lsb_req_en,
  input  logic                     din,
  output logic                     sclk,
  output logic                     fs_n,
  output logic                     fsd_n,
  output logic                     sec_flag
);
  localparam int NW = $clog2(N_MAX);
  localparam int HW = NW + 1;
  localparam int SW = $clog2(2 * BASE_SLOTS);

  logic          rise_tick, fall_tick, wrap, big_d, sec_d;
  logic [HW-1:0] half_len;
  logic [SW-1:0] slot_q, slot_d;
  fsg_pins_t     pins;

  fsg_sclk_div #(.HW(HW)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_len  (half_len),
    .sclk      (sclk),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  fsg_slot_ctr #(
    .N_MAX(N_MAX), .BASE_SLOTS(BASE_SLOTS), .NW(NW), .HW(HW), .SW(SW)
  ) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .div_n     (div_n),
    .big_in    (big_cascade),
    .slot_q    (slot_q),
    .slot_d    (slot_d),
    .big_d     (big_d),
    .half_len  (half_len),
    .wrap      (wrap)
  );

  fsg_req_ctl #(.SW(SW), .WORD_BITS(WORD_BITS)) u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_tick  (rise_tick),
    .fall_tick  (fall_tick),
    .wrap       (wrap),
    .slot_q     (slot_q),
    .fc_req     (fc_req),
    .lsb_req_en (lsb_req_en),
    .din        (din),
    .sec_d      (sec_d)
  );

  fsg_frame_out #(
    .SW(SW), .BASE_SLOTS(BASE_SLOTS), .WORD_BITS(WORD_BITS)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .slot_d    (slot_d),
    .big_d     (big_d),
    .sec_d     (sec_d),
    .pins      (pins)
  );

  assign fs_n     = pins.fs_n;
  assign fsd_n    = pins.fsd_n;
  assign sec_flag = pins.flag;
endmodule

// File: rtl/fsg_timing_chk.sv
module fsg_timing_chk #(
  parameter int N_MAX = 32
) (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic fs_n,
  input logic fsd_n,
  input logic sec_flag
);
  localparam int CW = $clog2(N_MAX) + 2;

  logic [CW-1:0] hold_q;
  logic          sclk_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      sclk_p <= 1'b0;
    end else begin
      sclk_p <= sclk;
      hold_q <= (sclk != sclk_p) ? '0 : hold_q + CW'(1);
    end
  end

  // R2
  sclk_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q <= CW'(N_MAX));

  // R3
  fs_on_sclk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_n) |-> $rose(sclk));

  // R9
  fs_fsd_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fs_n && !fsd_n));

  // R9
  fsd_follows_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsd_n) |-> $rose(fs_n));

  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_flag) |-> $fell(fs_n));

  // R8
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_flag) |-> $fell(fs_n));
endmodule

bind fsg_timing_gen fsg_timing_chk #(.N_MAX(N_MAX)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk     (sclk),
  .fs_n     (fs_n),
  .fsd_n    (fsd_n),
  .sec_flag (sec_flag)
);

// File: tb/test_fsg_timing_gen.sv
module test_fsg_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] div_n;
  logic       big_cascade, fc_req, lsb_req_en, din;
  logic       sclk, fs_n, fsd_n, sec_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fsg_timing_gen i_fsg_timing_gen (
    .clk(clk), .rst_n(rst_n), .div_n(div_n), .big_cascade(big_cascade),
    .fc_req(fc_req), .lsb_req_en(lsb_req_en), .din(din),
    .sclk(sclk), .fs_n(fs_n), .fsd_n(fsd_n), .sec_flag(sec_flag)
  );

  // Period monitor, sampled on the falling clock edge.
  int period_id = 0;
  int cyc, rises, pri_low, sec_low, fsd_low, fl_hi, sec_cnt, sec_off, fsd_off;
  int s_cyc, s_rises, s_pri_low, s_sec_low, s_fsd_low, s_fl_hi, s_sec_cnt, s_sec_off, s_fsd_off;
  logic p_sclk, p_fs, p_fsd;
  bit armed;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_sclk = 1'b0; p_fs = 1'b1; p_fsd = 1'b1; armed = 1'b0;
    end else begin
      if (p_fs && !fs_n && !sec_flag) begin
        if (armed) begin
          s_cyc = cyc; s_rises = rises; s_pri_low = pri_low; s_sec_low = sec_low;
          s_fsd_low = fsd_low; s_fl_hi = fl_hi; s_sec_cnt = sec_cnt;
          s_sec_off = sec_off; s_fsd_off = fsd_off;
        end
        armed = 1'b1;
        cyc = 0; rises = 0; pri_low = 0; sec_low = 0; fsd_low = 0; fl_hi = 0;
        sec_cnt = 0; sec_off = -1; fsd_off = -1;
        period_id++;
      end
      cyc++;
      if (!p_sclk && sclk) rises++;
      if (!fs_n && !sec_flag) pri_low++;
      if (!fs_n && sec_flag) sec_low++;
      if (!fsd_n) fsd_low++;
      if (sec_flag) fl_hi++;
      if (p_fs && !fs_n && sec_flag) begin sec_cnt++; sec_off = rises - 1; end
      if (p_fsd && !fsd_n && fsd_off < 0) fsd_off = rises - 1;
      p_sclk = sclk; p_fs = fs_n; p_fsd = fsd_n;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_primary();
    int t;
    t = period_id;
    do @(posedge clk); while (period_id == t);
    #1;
  endtask

  // {div_n[4:0], big_cascade, fc_req, lsb_req_en, din, expect_secondary}
  localparam logic [9:0] VEC_TAB [9] = '{
    {5'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd2, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {5'd1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd4, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    {5'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    int first;
    rst_n = 1'b0; div_n = 5'd1; big_cascade = 1'b0;
    fc_req = 1'b0; lsb_req_en = 1'b0; din = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 fs_n in reset", int'(fs_n), 1);
    chk("R1 fsd_n in reset", int'(fsd_n), 1);
    chk("R1 sclk in reset", int'(sclk), 0);
    chk("R1 sec_flag in reset", int'(sec_flag), 0);
    rst_n = 1'b1;
    first = -1;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (sclk) begin first = k; break; end
    end
    chk("R1 first SCLK rise edge", first, 32);
    chk("R1 fs_n falls with first rise", int'(fs_n), 0);

    // R6: request raised only after its sampling edge is ignored
    div_n = 5'd2;
    wait_primary();
    do @(negedge clk); while (!fs_n);
    fc_req = 1'b1;
    repeat (300) @(negedge clk);
    fc_req = 1'b0;
    wait_primary();
    chk("R6 late fc_req gives no secondary", s_sec_cnt, 0);
    chk("R8 flag idle without secondary", s_fl_hi, 0);

    // R10: mid-period change of divider and cascade size
    wait_primary();
    do @(negedge clk); while (!fs_n);
    div_n = 5'd3; big_cascade = 1'b1;
    wait_primary();
    chk("R10 running period keeps old length", s_cyc, 2 * 2 * 256);
    chk("R10 running period keeps old SCLK count", s_rises, 256);
    wait_primary();
    chk("R10 next period uses new settings", s_cyc, 2 * 3 * 512);

    for (int v = 0; v < 9; v++) begin
      logic [9:0] e;
      int n, p, mid, xs;
      string rp, rs;
      e = VEC_TAB[v];
      div_n = e[9:5]; big_cascade = e[4]; fc_req = e[3];
      lsb_req_en = e[2]; din = e[1];
      n   = (e[9:5] == 5'd0) ? 32 : int'(e[9:5]);
      p   = e[4] ? 512 : 256;
      mid = p / 2;
      xs  = int'(e[0]);
      rp  = e[4] ? "R4" : "R3";
      if (e[3])             rs = "R5";
      else if (e[2] | e[1]) rs = "R7";
      else                  rs = "R6";
      wait_primary();
      wait_primary();
      chk("R2 period clocks", s_cyc, 2 * n * p);
      chk({rp, " SCLK cycles per period"}, s_rises, p);
      chk("R3 primary fs_n low clocks", s_pri_low, 32 * n);
      chk({rs, " secondary frame count"}, s_sec_cnt, xs);
      if (xs != 0) begin
        chk({rs, " secondary offset"}, s_sec_off, mid);
        chk({rs, " secondary fs_n low clocks"}, s_sec_low, 32 * n);
      end
      chk("R8 flag high clocks", s_fl_hi, xs * (p - mid) * 2 * n);
      chk("R9 fsd_n start slot", s_fsd_off, 16);
      chk("R9 fsd_n low clocks", s_fsd_low, (xs != 0 ? 64 : 32) * n);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule